// File: doc/BRIEF.md
# Interval Timer Peripheral

A 32-bit down-counting interval timer behind a small word-addressed register interface, with a single level-sensitive interrupt. Software programs a reload limit, picks periodic or one-shot operation, starts the timer, and is interrupted when the count runs out. The counter moves by one on each clock cycle in which the external tick strobe is high. That strobe comes from a prescaler that lives outside this block.

The register interface is a set of plain strobes. It has no valid/ready handshake and never back-pressures. A write is taken in the cycle in which `reg_wr` is high. A read strobe is always accepted, and its data appears on `reg_rdata` one cycle later, marked by `reg_rvalid`. Every port is a plain control or status pin.

Register word indices:

| Index | Register | Access |
|-------|----------|--------|
| 0 | identifier | read-only |
| 1 | run | read/write |
| 2 | one-shot | read/write |
| 3 | limit | read/write |
| 4 | count | read/write |
| 5 | irq enable | read/write |
| 6 | irq status | read/write-one-to-clear |
| 7 | tick rate | read-only |

Top module: `ival_timer`

## Requirements
- R1: The word index is address bits [11:2]. Address bits above bit 11 are ignored. Indices 8 to 1023 read as 0, and writes to them change nothing.
- R2: Index 0 reads the constant DEV_ID and index 7 reads the constant TICK_HZ. Writes to either change nothing.
- R3: While run is 1, each cycle with `tick_en` high lowers the count by one. While run is 0 the count holds.
- R4: Writing index 1 sets run to 1 for a nonzero value and to 0 for zero. Reading index 1 returns 0 or 1. Writing the value run already holds changes nothing.
- R5: Expiry is the tick that moves the count from 1 to 0. It sets irq status to 1. In periodic mode (one-shot = 0) that same tick reloads the count from the limit.
- R6: In one-shot mode (one-shot = 1), expiry leaves the count at 0 and clears run to 0.
- R7: Writing index 3 stores the limit and also loads the count with the written value. Writing index 4 loads the count and leaves the limit unchanged.
- R8: Writing index 2 sets one-shot to 1 for a nonzero value and to 0 for zero. The count is left unchanged. Reading index 2 returns 0 or 1.
- R9: `irq` is high exactly when irq status is 1 and the irq enable word is nonzero. It follows a write or an expiry in the next cycle.
- R10: Writing index 6 with bit 0 set clears irq status. Writing it with bit 0 clear leaves the status unchanged. If an expiry falls in the same cycle as the clear, the status ends up set.
- R11: A running timer whose count is 0 does not count and raises no interrupt. This covers a limit of 0.
- R12: Read data and `reg_rvalid` appear one cycle after `reg_rd`. After reset, run, one-shot, limit, count, irq enable and irq status all read 0, and `irq` is low.
- R13: A tick in the same cycle as a write to index 1, 2, 3 or 4 is not applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count strobe, one decrement per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 32 | Byte address; bits [11:2] select the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read strobe |
| reg_rvalid | output | 1 | Marks valid read data |
| irq | output | 1 | Level interrupt |

## Verification
A wrong count shows up on the next read of index 4. The error also drifts the cycle of the next expiry, and that drift becomes visible on `irq` up to one limit period later. A run or one-shot flag held in the wrong state shows the very next tick: the count either fails to move or keeps moving past 0. For that reason the bench sweeps every tick count across several small limits in both modes and compares the count and status against a closed-form expression. A lost or sticky status bit shows on `irq` in the cycle after the event that should have changed it.

// File: rtl/ival_timer_pkg.sv
package ival_timer_pkg;
  localparam int unsigned NUM_REGS = 8;

  typedef enum logic [2:0] {
    IDX_ID      = 3'd0,
    IDX_RUN     = 3'd1,
    IDX_ONESHOT = 3'd2,
    IDX_LIMIT   = 3'd3,
    IDX_COUNT   = 3'd4,
    IDX_IEN     = 3'd5,
    IDX_ISTAT   = 3'd6,
    IDX_RATE    = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic run;
    logic oneshot;
    logic limit;
    logic count;
    logic ien;
    logic istat;
  } wr_sel_t;
endpackage

// File: rtl/ival_timer_regs.sv
module ival_timer_regs
  import ival_timer_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned WIN_BITS = 12,
  parameter logic [31:0] DEV_ID   = 32'h7100_0A01,
  parameter logic [31:0] TICK_HZ  = 32'd1_000_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic          run_q,
  input  logic          oneshot_q,
  input  logic [DW-1:0] limit_q,
  input  logic [DW-1:0] count_q,
  input  logic [DW-1:0] ien_q,
  input  logic          ist_q,
  output wr_sel_t       wr_sel,
  output logic [DW-1:0] reg_rdata,
  output logic          reg_rvalid
);
  localparam int unsigned IDXW = WIN_BITS - 2;
  localparam int unsigned SELW = $clog2(NUM_REGS);

  logic [IDXW-1:0] idx;
  logic            hit;
  logic [SELW-1:0] sel;
  logic [NUM_REGS-1:0] wr_hot;
  logic [DW-1:0]   rd_mux;

  assign idx = reg_addr[WIN_BITS-1:2];
  assign hit = (idx[IDXW-1:SELW] == '0);
  assign sel = idx[SELW-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_wdec
    assign wr_hot[i] = reg_wr && hit && (sel == SELW'(i));
  end

  assign wr_sel.run     = wr_hot[IDX_RUN];
  assign wr_sel.oneshot = wr_hot[IDX_ONESHOT];
  assign wr_sel.limit   = wr_hot[IDX_LIMIT];
  assign wr_sel.count   = wr_hot[IDX_COUNT];
  assign wr_sel.ien     = wr_hot[IDX_IEN];
  assign wr_sel.istat   = wr_hot[IDX_ISTAT];

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      unique case (reg_idx_e'(sel))
        IDX_ID:      rd_mux = DW'(DEV_ID);
        IDX_RUN:     rd_mux = DW'(run_q);
        IDX_ONESHOT: rd_mux = DW'(oneshot_q);
        IDX_LIMIT:   rd_mux = limit_q;
        IDX_COUNT:   rd_mux = count_q;
        IDX_IEN:     rd_mux = ien_q;
        IDX_ISTAT:   rd_mux = DW'(ist_q);
        IDX_RATE:    rd_mux = DW'(TICK_HZ);
        default:     rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/ival_timer_counter.sv
module ival_timer_counter
  import ival_timer_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  wr_sel_t       wr_sel,
  input  logic [DW-1:0] wdata,
  output logic          run_q,
  output logic          oneshot_q,
  output logic [DW-1:0] limit_q,
  output logic [DW-1:0] count_q,
  output logic          ctl_wr,
  output logic          expire
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic tick_go;

  // any write to run, mode, limit or count takes the cycle from the tick
  assign ctl_wr  = wr_sel.run | wr_sel.oneshot | wr_sel.limit | wr_sel.count;
  assign tick_go = tick_en && run_q && !ctl_wr && (count_q != '0);
  assign expire  = tick_go && (count_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      oneshot_q <= 1'b0;
      limit_q   <= '0;
      count_q   <= '0;
    end else begin
      if (wr_sel.run)     run_q     <= |wdata;
      if (wr_sel.oneshot) oneshot_q <= |wdata;
      if (wr_sel.limit) begin
        limit_q <= wdata;
        count_q <= wdata;
      end
      if (wr_sel.count) count_q <= wdata;
      if (tick_go) begin
        if (expire) begin
          count_q <= oneshot_q ? '0 : limit_q;
          if (oneshot_q) run_q <= 1'b0;
        end else begin
          count_q <= count_q - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/ival_timer_irq.sv
module ival_timer_irq
  import ival_timer_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  wr_sel_t       wr_sel,
  input  logic [DW-1:0] wdata,
  input  logic          expire,
  output logic [DW-1:0] ien_q,
  output logic          ist_q,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= '0;
      ist_q <= 1'b0;
    end else begin
      if (wr_sel.ien) ien_q <= wdata;
      if (wr_sel.istat && wdata[0]) ist_q <= 1'b0;
      if (expire) ist_q <= 1'b1;
    end
  end

  assign irq = ist_q && (ien_q != '0);
endmodule

// File: rtl/ival_timer.sv
module ival_timer
  import ival_timer_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned WIN_BITS = 12,
  parameter logic [31:0] DEV_ID   = 32'h7100_0A01,
  parameter logic [31:0] TICK_HZ  = 32'd1_000_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          reg_rvalid,
  output logic          irq
);
  wr_sel_t       wr_sel;
  logic          run_w;
  logic          oneshot_w;
  logic [DW-1:0] limit_w;
  logic [DW-1:0] count_w;
  logic [DW-1:0] ien_w;
  logic          ist_w;
  logic          ctl_wr_w;
  logic          expire_w;

  ival_timer_regs #(
    .AW(AW), .DW(DW), .WIN_BITS(WIN_BITS), .DEV_ID(DEV_ID), .TICK_HZ(TICK_HZ)
  ) regs_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .run_q(run_w), .oneshot_q(oneshot_w), .limit_q(limit_w), .count_q(count_w),
    .ien_q(ien_w), .ist_q(ist_w), .wr_sel(wr_sel),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
  );

  ival_timer_counter #(.DW(DW)) cnt_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_sel(wr_sel), .wdata(reg_wdata),
    .run_q(run_w), .oneshot_q(oneshot_w), .limit_q(limit_w), .count_q(count_w),
    .ctl_wr(ctl_wr_w), .expire(expire_w)
  );

  ival_timer_irq #(.DW(DW)) irq_i (
    .clk(clk), .rst(rst), .wr_sel(wr_sel), .wdata(reg_wdata), .expire(expire_w),
    .ien_q(ien_w), .ist_q(ist_w), .irq(irq)
  );
endmodule

// File: rtl/ival_timer_checker.sv
module ival_timer_checker #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_rd,
  input logic          reg_rvalid,
  input logic          expire,
  input logic          oneshot,
  input logic          run,
  input logic [DW-1:0] count,
  input logic          ctl_wr,
  input logic          ist,
  input logic          irq
);
  a_r12_rd_latency: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);
  a_r12_no_stray_valid: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> !reg_rvalid);
  a_r5_expire_sets_status: assert property (@(posedge clk) disable iff (rst)
    expire |=> ist);
  a_r6_oneshot_halts: assert property (@(posedge clk) disable iff (rst)
    (expire && oneshot) |=> (!run && count == '0));
  a_r3_frozen_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run && !ctl_wr) |=> $stable(count));
  a_r11_zero_stays_idle: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !ctl_wr) |=> (count == '0 && !expire));
  a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (rst)
    irq |-> ist);
endmodule

bind ival_timer ival_timer_checker #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_rvalid(reg_rvalid),
  .expire(expire_w), .oneshot(oneshot_w), .run(run_w), .count(count_w),
  .ctl_wr(ctl_wr_w), .ist(ist_w), .irq(irq)
);

// File: tb/ival_timer_tb_top.sv
module ival_timer_tb_top;
  localparam logic [31:0] T_ID   = 32'h5A5A_0C01;
  localparam logic [31:0] T_RATE = 32'd32768;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  ival_timer #(.DEV_ID(T_ID), .TICK_HZ(T_RATE)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_a(logic [31:0] a, logic [31:0] d, logic tk = 1'b0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; tick_en = tk;
    @(negedge clk);
    reg_wr = 1'b0; tick_en = 1'b0;
  endtask

  task automatic wr(int idx, logic [31:0] d, logic tk = 1'b0);
    wr_a(32'(idx) << 2, d, tk);
  endtask

  task automatic rd_a(logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    check("R12 rvalid", 32'(reg_rvalid), 32'd1);
    d = reg_rdata;
  endtask

  task automatic rd(int idx, output logic [31:0] d);
    rd_a(32'(idx) << 2, d);
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    check("R12 rvalid idle", 32'(reg_rvalid), 0);
    check("R12 irq reset", 32'(irq), 0);
    for (int i = 1; i <= 6; i++) begin
      rd(i, v); check("R12 reset value", v, 0);
    end

    // R2 constants, writes ignored
    wr(0, 32'hFFFF_FFFF); wr(7, 32'h1);
    rd(0, v); check("R2 id", v, T_ID);
    rd(7, v); check("R2 rate", v, T_RATE);

    // R1 decode: undefined indices, upper address bits ignored
    wr(9, 32'h55); wr(1023, 32'h77);
    rd(8, v);    check("R1 undefined idx 8", v, 0);
    rd(1023, v); check("R1 undefined idx 1023", v, 0);
    wr_a(32'hABCD_E00C, 32'd9);  // alias of index 3
    rd_a(32'h1234_500C, v); check("R1 alias limit", v, 9);
    rd(4, v); check("R7 limit loads count", v, 9);
    rd(1, v); check("R1 no stray run", v, 0);

    // R3 stopped: ticks do not move the count
    ticks(5);
    rd(4, v); check("R3 frozen when stopped", v, 9);

    // R7 count write leaves limit
    wr(4, 32'd4);
    rd(4, v); check("R7 count write", v, 4);
    rd(3, v); check("R7 limit unchanged", v, 9);

    // R3/R5 periodic sweep, count = L - (k mod L), status = (k >= L)
    for (int L = 1; L <= 5; L++) begin
      for (int k = 0; k <= 2 * L + 1; k++) begin
        wr(3, 32'(L)); wr(6, 32'd1); wr(1, 32'd1);
        ticks(k);
        wr(1, 32'd0);
        rd(4, v); check("R5 periodic count", v, 32'(L - (k % L)));
        rd(6, v); check("R5 periodic status", v, (k >= L) ? 32'd1 : 32'd0);
      end
    end

    // R6 one-shot sweep
    wr(2, 32'd3);
    rd(2, v); check("R8 oneshot readback", v, 1);
    for (int L = 1; L <= 4; L++) begin
      for (int k = 0; k <= L + 1; k++) begin
        wr(3, 32'(L)); wr(6, 32'd1); wr(1, 32'd1);
        ticks(k);
        rd(1, v); check("R6 oneshot run", v, (k < L) ? 32'd1 : 32'd0);
        rd(4, v); check("R6 oneshot count", v, (k < L) ? 32'(L - k) : 32'd0);
        rd(6, v); check("R6 oneshot status", v, (k >= L) ? 32'd1 : 32'd0);
        wr(1, 32'd0);
      end
    end

    // R8 mode write while running: count kept, coincident tick dropped (R13)
    wr(3, 32'd10); wr(1, 32'd5);
    rd(1, v); check("R4 run readback", v, 1);
    ticks(2);
    wr(2, 32'd0, 1'b1);
    rd(4, v); check("R8 R13 mode write keeps count", v, 8);
    rd(2, v); check("R8 mode cleared", v, 0);
    // R4 same-value write is a no-op and drops the tick (R13)
    wr(1, 32'd7, 1'b1);
    rd(1, v); check("R4 same value run", v, 1);
    rd(4, v); check("R4 R13 tick dropped", v, 8);
    ticks(3);
    rd(4, v); check("R3 still counting", v, 5);
    wr(3, 32'd20, 1'b1);
    rd(4, v); check("R13 limit write wins tick", v, 20);

    // R11 limit zero stays idle
    wr(6, 32'd1); wr(5, 32'd1); wr(3, 32'd0);
    ticks(6);
    rd(4, v); check("R11 zero count idle", v, 0);
    check("R11 no irq", 32'(irq), 0);

    // R9 irq gating and R10 write-one-to-clear
    wr(3, 32'd2); ticks(2);
    check("R9 irq raised", 32'(irq), 1);
    wr(5, 32'd0);
    check("R9 irq masked", 32'(irq), 0);
    wr(5, 32'h100);
    check("R9 any enable bit", 32'(irq), 1);
    wr(6, 32'd2);
    check("R10 bit0 clear keeps status", 32'(irq), 1);
    wr(6, 32'd1);
    check("R10 clear status", 32'(irq), 0);
    ticks(1);
    // count now 1: expiry together with a clear leaves status set
    wr(6, 32'd1, 1'b1);
    rd(6, v); check("R10 expiry beats clear", v, 1);
    check("R9 irq after expiry", 32'(irq), 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule